// File: doc/BRIEF.md
# Two-Level Page Table Walker

When the translation cache misses, this block converts a page number into a physical frame. It reads two linked tables in memory. A 32-bit logical address is split into three fields. Bits [31:22] index the outer table. Bits [21:12] index an inner table. Bits [11:0] are the offset inside a 4 KB page, and the walker never uses them. Every table entry is one 32-bit word, so a table of 1,024 entries fills exactly one page.

A request is accepted only when the walker is idle. At that moment the walker latches the table base and the table length. It then checks the outer index against the length. If the index is in range, it issues the outer read and waits for the response. It issues the inner read only after the outer entry has arrived.

The walker finishes with a one-cycle result pulse. The pulse carries either a frame number with its write permission, or a fault code. The original page number comes back with the result so the cache can be refilled.

Top module: `ptWalker`

## Requirements
- R1: After reset, `reqReady` is 1, and both `resValid` and `memReqValid` are 0.
- R2: The first memory read of a walk is at `tableBase + 4 * addr[31:22]`, using the base value sampled in the accepting cycle.
- R3: The second read is at `{outerEntry[31:12], addr[21:12], 2'b00}`. It is issued only after the outer response has been received.
- R4: A walk whose entries are both valid makes exactly two reads. Its result pulse has fault code 0, `resFrame = innerEntry[31:12]`, `resWritable = innerEntry[1]` and `resPage = addr[31:12]`.
- R5: If the outer index is greater than or equal to `tableLen`, the walk ends with fault code 1 and no memory read. `resValid` rises in the cycle right after acceptance.
- R6: If the outer entry has bit 0 (valid) clear, the walk ends with fault code 2 after exactly one read.
- R7: If the inner entry has bit 0 clear, the walk ends with fault code 3 after exactly two reads.
- R8: `reqReady` is 0 from acceptance up to and including the result cycle. Requests presented in that time are ignored and do not change the running walk.
- R9: While `memReqValid` is 1 and `memReqReady` is 0, `memReqValid` stays 1 and `memReqAddr` stays unchanged.
- R10: `resValid` is a single-cycle pulse and is never 1 in the same cycle as `memReqValid`.
- R11: A change to `tableBase` after acceptance has no effect on the running walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Translation request present |
| reqAddr | input | 32 | Logical address to translate |
| reqReady | output | 1 | Walker idle, request accepted this cycle |
| tableBase | input | 32 | Byte address of the outer table |
| tableLen | input | 11 | Number of usable outer entries (0 to 1024) |
| memReqValid | output | 1 | Memory read request |
| memReqAddr | output | 32 | Byte address of the entry to read |
| memReqReady | input | 1 | Memory accepts the read |
| memRspValid | input | 1 | Read data returned |
| memRspData | input | 32 | Entry word: [31:12] frame, [1] writable, [0] valid |
| resValid | output | 1 | Result pulse |
| resFaultCode | output | 2 | 0 none, 1 length, 2 outer invalid, 3 inner invalid |
| resPage | output | 20 | Page number of the request |
| resFrame | output | 20 | Translated frame number |
| resWritable | output | 1 | Write permission from the inner entry |

## Verification
Suppose the state register or the pending flag is corrupted. The ports show a wrong read count within one walk, for example a missing, extra or repeated read, or a result pulse that never arrives. Suppose instead the address register or the fault register is wrong. The logged read addresses or the fault code of that same walk differ from the expected values. The bench compares each address against values it builds itself from the entry layout. Timing faults show up as a cycle-count check on the length fault and as a hold check during memory stalls.

// File: rtl/ptWalkPkg.sv
package ptWalkPkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ_OUTER,
    ST_READ_INNER,
    ST_DONE,
    ST_FAULT
  } walkState_t;

  typedef enum logic [1:0] {
    FLT_NONE   = 2'd0,
    FLT_LENGTH = 2'd1,
    FLT_OUTER  = 2'd2,
    FLT_INNER  = 2'd3
  } faultCode_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic captureReq;   // request accepted in idle
    logic outerRsp;     // outer entry arriving
    logic innerRsp;     // inner entry arriving
  } walkStrobe_t;

  localparam int ENTRY_VALID_BIT = 0;
  localparam int ENTRY_WRITE_BIT = 1;

endpackage

// File: rtl/ptwControl.sv
module ptwControl
  import ptWalkPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        lenFault,
  input  logic        rspEntryValid,
  input  logic        memReqReady,
  input  logic        memRspValid,
  output logic        reqReady,
  output logic        memReqValid,
  output logic        resValid,
  output walkStrobe_t strobe
);

  walkState_t state, stateNext;
  logic       pending;

  always_comb begin
    stateNext = state;
    strobe    = '0;
    unique case (state)
      ST_IDLE: begin
        if (reqValid) begin
          strobe.captureReq = 1'b1;
          stateNext = lenFault ? ST_FAULT : ST_READ_OUTER;
        end
      end
      ST_READ_OUTER: begin
        if (pending && memRspValid) begin
          strobe.outerRsp = 1'b1;
          stateNext = rspEntryValid ? ST_READ_INNER : ST_FAULT;
        end
      end
      ST_READ_INNER: begin
        if (pending && memRspValid) begin
          strobe.innerRsp = 1'b1;
          stateNext = rspEntryValid ? ST_DONE : ST_FAULT;
        end
      end
      ST_DONE, ST_FAULT: stateNext = ST_IDLE;
      default:           stateNext = ST_IDLE;
    endcase
  end

  assign reqReady    = (state == ST_IDLE);
  assign memReqValid = ((state == ST_READ_OUTER) || (state == ST_READ_INNER)) && !pending;
  assign resValid    = (state == ST_DONE) || (state == ST_FAULT);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      pending <= 1'b0;
    end else begin
      state <= stateNext;
      if (memReqValid && memReqReady)
        pending <= 1'b1;
      else if (pending && memRspValid)
        pending <= 1'b0;
    end
  end

  // R9: a read that is not yet accepted stays asserted
  assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqReady) |=> memReqValid);

  // R10: the result is a single-cycle pulse
  assert_res_pulse_R10: assert property (@(posedge clk) disable iff (!rstN)
    resValid |=> !resValid);

endmodule

// File: rtl/ptwDatapath.sv
module ptwDatapath
  import ptWalkPkg::*;
#(
  parameter int IDX_W     = 10,
  parameter int ENT_SHIFT = 2,
  localparam int OFFS_W   = IDX_W + ENT_SHIFT,
  localparam int VA_W     = 2 * IDX_W + OFFS_W,
  localparam int PAGE_W   = VA_W - OFFS_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  walkStrobe_t       strobe,
  input  logic [VA_W-1:0]   reqAddr,
  input  logic [VA_W-1:0]   tableBase,
  input  logic [IDX_W:0]    tableLen,
  input  logic [VA_W-1:0]   memRspData,
  output logic              lenFault,
  output logic              rspEntryValid,
  output logic [VA_W-1:0]   memReqAddr,
  output logic [PAGE_W-1:0] resPage,
  output logic [PAGE_W-1:0] resFrame,
  output logic              resWritable,
  output logic [1:0]        resFaultCode
);

  logic [IDX_W-1:0]  outerIdx;
  logic [VA_W-1:0]   outerOffset;
  logic [VA_W-1:0]   innerAddr;
  logic [PAGE_W-1:0] pageReg;
  logic [PAGE_W-1:0] frameReg;
  logic [VA_W-1:0]   addrReg;
  logic              writableReg;
  faultCode_t        faultReg;

  assign outerIdx      = reqAddr[VA_W-1 -: IDX_W];
  assign outerOffset   = {{(VA_W-IDX_W-ENT_SHIFT){1'b0}}, outerIdx, {ENT_SHIFT{1'b0}}};
  assign lenFault      = ({1'b0, outerIdx} >= tableLen);
  assign rspEntryValid = memRspData[ENTRY_VALID_BIT];
  assign innerAddr     = {memRspData[VA_W-1:OFFS_W], pageReg[IDX_W-1:0], {ENT_SHIFT{1'b0}}};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pageReg     <= '0;
      frameReg    <= '0;
      addrReg     <= '0;
      writableReg <= 1'b0;
      faultReg    <= FLT_NONE;
    end else begin
      if (strobe.captureReq) begin
        pageReg  <= reqAddr[VA_W-1:OFFS_W];
        addrReg  <= tableBase + outerOffset;
        faultReg <= lenFault ? FLT_LENGTH : FLT_NONE;
      end
      if (strobe.outerRsp) begin
        addrReg <= innerAddr;
        if (!rspEntryValid) faultReg <= FLT_OUTER;
      end
      if (strobe.innerRsp) begin
        frameReg    <= memRspData[VA_W-1:OFFS_W];
        writableReg <= memRspData[ENTRY_WRITE_BIT];
        if (!rspEntryValid) faultReg <= FLT_INNER;
      end
    end
  end

  assign memReqAddr   = addrReg;
  assign resPage      = pageReg;
  assign resFrame     = frameReg;
  assign resWritable  = writableReg;
  assign resFaultCode = faultReg;

  // R6, R7: once a fault is recorded, no later response of the same walk alters it
  assert_fault_sticky_R6: assert property (@(posedge clk) disable iff (!rstN)
    (faultReg != FLT_NONE && !strobe.captureReq) |=> faultReg == $past(faultReg));

  // R4: the frame delivered is the one carried by the inner response
  assert_inner_frame_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.innerRsp |=> resFrame == $past(memRspData[VA_W-1:OFFS_W]));

endmodule

// File: rtl/ptWalker.sv
module ptWalker
  import ptWalkPkg::*;
#(
  parameter int IDX_W     = 10,
  parameter int ENT_SHIFT = 2,
  localparam int OFFS_W   = IDX_W + ENT_SHIFT,
  localparam int VA_W     = 2 * IDX_W + OFFS_W,
  localparam int PAGE_W   = VA_W - OFFS_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [VA_W-1:0]   reqAddr,
  output logic              reqReady,
  input  logic [VA_W-1:0]   tableBase,
  input  logic [IDX_W:0]    tableLen,
  output logic              memReqValid,
  output logic [VA_W-1:0]   memReqAddr,
  input  logic              memReqReady,
  input  logic              memRspValid,
  input  logic [VA_W-1:0]   memRspData,
  output logic              resValid,
  output logic [1:0]        resFaultCode,
  output logic [PAGE_W-1:0] resPage,
  output logic [PAGE_W-1:0] resFrame,
  output logic              resWritable
);

  walkStrobe_t strobe;
  logic        lenFault;
  logic        rspEntryValid;

  ptwControl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .reqValid     (reqValid),
    .lenFault     (lenFault),
    .rspEntryValid(rspEntryValid),
    .memReqReady  (memReqReady),
    .memRspValid  (memRspValid),
    .reqReady     (reqReady),
    .memReqValid  (memReqValid),
    .resValid     (resValid),
    .strobe       (strobe)
  );

  ptwDatapath #(.IDX_W(IDX_W), .ENT_SHIFT(ENT_SHIFT)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .reqAddr      (reqAddr),
    .tableBase    (tableBase),
    .tableLen     (tableLen),
    .memRspData   (memRspData),
    .lenFault     (lenFault),
    .rspEntryValid(rspEntryValid),
    .memReqAddr   (memReqAddr),
    .resPage      (resPage),
    .resFrame     (resFrame),
    .resWritable  (resWritable),
    .resFaultCode (resFaultCode)
  );

  // R9: a stalled read keeps its address
  assert_addr_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqReady) |=> $stable(memReqAddr));

  // R5: an out-of-range outer index faults next cycle with no read
  assert_len_fault_R5: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && lenFault) |=> (resValid && !memReqValid && resFaultCode == FLT_LENGTH));

  // R10: result and memory request never overlap
  assert_no_overlap_R10: assert property (@(posedge clk) disable iff (!rstN)
    !(resValid && memReqValid));

endmodule

// File: tb/ptWalker_bench.sv
module ptWalker_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [31:0] reqAddr = '0;
  logic        reqReady;
  logic [31:0] tableBase = 32'h0004_0000;
  logic [10:0] tableLen = 11'd16;
  logic        memReqValid;
  logic [31:0] memReqAddr;
  logic        memReqReady = 1'b1;
  logic        memRspValid = 1'b0;
  logic [31:0] memRspData = '0;
  logic        resValid;
  logic [1:0]  resFaultCode;
  logic [19:0] resPage;
  logic [19:0] resFrame;
  logic        resWritable;

  int vectors = 0;
  int miscompares = 0;

  // memory model
  logic [31:0] memImg [logic [31:0]];
  int          rspLatency = 1;
  int          stallLeft = 0;
  int          countdown = 0;
  logic [31:0] savedAddr = '0;
  logic [31:0] addrLog [0:3];
  int          readCount = 0;
  logic [31:0] stallAddr = '0;
  bit          stallSeen = 0;
  bit          stallAddrBad = 0;

  // walk results
  int          gotCycles;
  bit          busyBad;
  logic [1:0]  gotCode;
  logic [19:0] gotPage;
  logic [19:0] gotFrame;
  logic        gotW;

  always #(CLK_PERIOD/2) clk = ~clk;

  ptWalker u_ptWalker (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr), .reqReady(reqReady),
    .tableBase(tableBase), .tableLen(tableLen), .memReqValid(memReqValid),
    .memReqAddr(memReqAddr), .memReqReady(memReqReady), .memRspValid(memRspValid),
    .memRspData(memRspData), .resValid(resValid), .resFaultCode(resFaultCode),
    .resPage(resPage), .resFrame(resFrame), .resWritable(resWritable)
  );

  function automatic logic [31:0] readMem(input logic [31:0] a);
    return memImg.exists(a) ? memImg[a] : 32'h0;
  endfunction

  function automatic logic [31:0] mkEntry(input logic [19:0] frame, input bit w, input bit v);
    return {frame, 10'b0, w, v};
  endfunction

  initial begin
    forever begin
      @(negedge clk);
      memRspValid = 1'b0;
      if (countdown > 0) begin
        countdown--;
        if (countdown == 0) begin
          memRspValid = 1'b1;
          memRspData  = readMem(savedAddr);
        end
      end
      if (memReqValid) begin
        if (stallLeft > 0) begin
          if (!stallSeen) begin stallAddr = memReqAddr; stallSeen = 1; end
          else if (memReqAddr !== stallAddr) stallAddrBad = 1;
          stallLeft--;
          memReqReady = 1'b0;
        end else begin
          if (stallSeen && memReqAddr !== stallAddr) stallAddrBad = 1;
          stallSeen   = 0;
          memReqReady = 1'b1;
          savedAddr   = memReqAddr;
          if (readCount < 4) addrLog[readCount] = memReqAddr;
          readCount++;
          countdown = rspLatency;
        end
      end else begin
        memReqReady = (stallLeft == 0);
      end
    end
  end

  task automatic checkVal(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // issue one walk; optional second request held during it and base change after accept
  task automatic runWalk(input logic [31:0] addr, input bit holdReq, input logic [31:0] otherAddr,
                         input bit changeBase, input logic [31:0] newBase);
    readCount = 0;
    busyBad   = 0;
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    reqAddr  = addr;
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = holdReq;
    if (holdReq) reqAddr = otherAddr;
    if (changeBase) tableBase = newBase;
    gotCycles = 1;
    while (!resValid && gotCycles < 500) begin
      if (reqReady) busyBad = 1;
      @(negedge clk);
      gotCycles++;
    end
    if (reqReady) busyBad = 1;
    gotCode  = resFaultCode;
    gotPage  = resPage;
    gotFrame = resFrame;
    gotW     = resWritable;
    reqValid = 1'b0;
    @(negedge clk);
  endtask

  task automatic testReset();
    @(negedge clk);
    checkVal("R1", "reqReady", {31'b0, reqReady}, 32'd1);
    checkVal("R1", "resValid", {31'b0, resValid}, 32'd0);
    checkVal("R1", "memReqValid", {31'b0, memReqValid}, 32'd0);
  endtask

  task automatic testWalkOk();
    // outer idx 1, inner idx 3
    runWalk(32'h0040_3ABC, 0, 0, 0, 0);
    checkVal("R2", "outer read addr", addrLog[0], 32'h0004_0004);
    checkVal("R3", "inner read addr", addrLog[1], 32'h0012_300C);
    checkVal("R4", "read count", readCount, 2);
    checkVal("R4", "fault code", {30'b0, gotCode}, 0);
    checkVal("R4", "frame", {12'b0, gotFrame}, 32'h000A_BCDE);
    checkVal("R4", "writable", {31'b0, gotW}, 1);
    checkVal("R4", "page", {12'b0, gotPage}, 32'h0000_0403);
    checkVal("R8", "ready low while busy", {31'b0, busyBad}, 0);
  endtask

  task automatic testLastIndex();
    // outer idx 15 (len-1 boundary), inner idx 1023, read-only page
    runWalk(32'h03FF_F123, 0, 0, 0, 0);
    checkVal("R2", "outer addr at last index", addrLog[0], 32'h0004_003C);
    checkVal("R3", "inner addr at last index", addrLog[1], 32'h0045_6FFC);
    checkVal("R4", "frame at last index", {12'b0, gotFrame}, 32'h0001_3579);
    checkVal("R4", "read-only bit", {31'b0, gotW}, 0);
    checkVal("R4", "fault code at last index", {30'b0, gotCode}, 0);
  endtask

  task automatic testLenFault();
    runWalk(32'h0400_0000, 0, 0, 0, 0);   // idx 16 == len
    checkVal("R5", "length fault code", {30'b0, gotCode}, 1);
    checkVal("R5", "no read on length fault", readCount, 0);
    checkVal("R5", "result one cycle after accept", gotCycles, 1);
    tableLen = 11'd0;
    runWalk(32'h0000_0000, 0, 0, 0, 0);
    checkVal("R5", "zero length faults idx 0", {30'b0, gotCode}, 1);
    checkVal("R5", "zero length no read", readCount, 0);
    tableLen = 11'd16;
  endtask

  task automatic testOuterInvalid();
    runWalk(32'h0080_0000, 0, 0, 0, 0);   // idx 2 entry absent -> invalid
    checkVal("R6", "outer invalid code", {30'b0, gotCode}, 2);
    checkVal("R6", "single read", readCount, 1);
    checkVal("R6", "outer addr", addrLog[0], 32'h0004_0008);
  endtask

  task automatic testInnerInvalid();
    runWalk(32'h0040_5000, 0, 0, 0, 0);   // idx 1, inner 5 absent
    checkVal("R7", "inner invalid code", {30'b0, gotCode}, 3);
    checkVal("R7", "two reads", readCount, 2);
    checkVal("R7", "inner addr", addrLog[1], 32'h0012_3014);
  endtask

  task automatic testStall();
    rspLatency = 3;
    stallLeft  = 3;
    stallAddrBad = 0;
    runWalk(32'h0040_3ABC, 0, 0, 0, 0);
    checkVal("R9", "address held in stall", {31'b0, stallAddrBad}, 0);
    checkVal("R9", "outer addr after stall", addrLog[0], 32'h0004_0004);
    checkVal("R9", "reads after stall", readCount, 2);
    checkVal("R9", "frame after stall", {12'b0, gotFrame}, 32'h000A_BCDE);
    rspLatency = 1;
  endtask

  task automatic testBusyIgnore();
    runWalk(32'h0040_3ABC, 1, 32'h03FF_F000, 0, 0);
    checkVal("R8", "ready low during held request", {31'b0, busyBad}, 0);
    checkVal("R8", "reads of first walk only", readCount, 2);
    checkVal("R8", "page of first request", {12'b0, gotPage}, 32'h0000_0403);
    @(negedge clk);
    checkVal("R8", "no walk started after drop", {31'b0, memReqValid}, 0);
    checkVal("R10", "pulse ended", {31'b0, resValid}, 0);
  endtask

  task automatic testBaseSampled();
    runWalk(32'h0040_3ABC, 0, 0, 1, 32'h0009_0000);
    checkVal("R11", "outer addr uses sampled base", addrLog[0], 32'h0004_0004);
    checkVal("R11", "frame unaffected", {12'b0, gotFrame}, 32'h000A_BCDE);
    tableBase = 32'h0004_0000;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog all requirements actual=hang expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    memImg[32'h0004_0004] = mkEntry(20'h00123, 0, 1);
    memImg[32'h0012_300C] = mkEntry(20'hABCDE, 1, 1);
    memImg[32'h0004_003C] = mkEntry(20'h00456, 0, 1);
    memImg[32'h0045_6FFC] = mkEntry(20'h13579, 0, 1);
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    testReset();
    testWalkOk();
    testLastIndex();
    testLenFault();
    testOuterInvalid();
    testInnerInvalid();
    testStall();
    testBusyIgnore();
    testBaseSampled();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule